// File: doc/BRIEF.md
# SPD EEPROM I2C Target

A 256-byte byte-addressed store that answers as a target on a two-wire I2C bus, holding the serial presence-detect description of a memory module. The bus master addresses the device with the fixed prefix `1010` followed by three strap bits. It sets the internal byte pointer with a write transaction, then reads one byte or a run of bytes, or stores a single byte. SDA is open-drain: the block sees the wired bus level on `sda_in` and pulls the line low by raising `sda_oe`. SCL and SDA are sampled by the system clock through a synchronizer. The block never stretches the clock.

The initial contents arrive over a valid/ready preload port. A transfer completes on a rising clock edge where `pl_valid` and `pl_ready` are both high. `pl_ready` is low for the whole of any bus transaction, from START to STOP. A preload source holds `pl_valid`, `pl_addr` and `pl_data` stable until the transfer completes. A sticky lock, raised by `lock_req`, write-protects the lower half of the store. The upper half stays writable. A background scanner adds up bytes 0 to 62 and compares the low eight bits of the sum with byte 63. It raises `csum_ok` when they match, and it starts a fresh scan whenever a write lands in that range.

Top module: `spd_eeprom`

## Requirements
- R1: The block acknowledges (drives SDA low in the ninth clock) only a first byte whose upper seven bits equal `{4'b1010, strap}`, with bit 0 as the read (1) / write (0) flag. For any other first byte it leaves SDA released and ignores the bus until the next START or STOP.
- R2: A write transaction that carries only a word-address byte sets the pointer. A repeated START followed by a read-addressed first byte returns the byte stored at that pointer, most significant bit first.
- R3: During a read, the pointer advances by one after each byte and wraps from 255 to 0. A master acknowledge continues with the next byte; a master no-acknowledge ends the read.
- R4: A write transaction stores the first data byte at the pointer and acknowledges it. Any further data byte in the same transaction is not acknowledged and is not stored.
- R5: A one-cycle `lock_req` pulse sets `locked` from the next cycle until reset. While `locked` is high, I2C writes to addresses 0 to 127 are still acknowledged, and preloads to those addresses are still accepted, but neither changes memory. Addresses 128 to 255 remain writable.
- R6: `pl_ready` is high only while no bus transaction is in progress. A preload transfer writes `pl_data` at `pl_addr`.
- R7: `csum_ok` is high when byte 63 equals the low 8 bits of the sum of bytes 0 to 62. Any write that changes memory in addresses 0 to 63 drops `csum_ok` in the next cycle, and the flag is valid again within 70 cycles.
- R8: After reset the memory holds all zeros, `locked` and `sda_oe` are low, `pl_ready` is high, and `csum_ok` rises within 70 cycles.
- R9: `sda_oe` rises only while SCL is low.
- R10: Before the lock is set, an I2C write to the lower half stores its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Wired bus data level |
| sda_oe | output | 1 | Pull SDA low when high |
| strap | input | 3 | Low three bits of the device address |
| pl_valid | input | 1 | Preload byte offered |
| pl_ready | output | 1 | Preload byte can be taken (bus idle) |
| pl_addr | input | 8 | Preload byte address |
| pl_data | input | 8 | Preload byte value |
| lock_req | input | 1 | Pulse to lock the lower half |
| locked | output | 1 | Lower half is write-protected |
| csum_ok | output | 1 | Byte 63 matches the sum of bytes 0 to 62 |

## Verification
The assertions watch, on every cycle, the pin-level rules that need no memory model. SDA is only pulled while SCL is low. The preload port is closed whenever the target drives the bus. The lock sets on request and never clears before reset. A preload into the checksum range drops `csum_ok` one cycle later. Data integrity can only be shown by the bench scenarios, which track memory with their own model. These cover random and wrapping sequential reads, address filtering, the single-byte write limit, the silent refusal of locked writes, and the checksum returning to valid after a rescan.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int SPD_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_READ,
    ST_IGNORE
  } spd_state_e;
endpackage

// File: rtl/spd_bus_sync.sv
module spd_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] lvl_q;

  assign raw = {sda_in, scl_in};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], raw[g]};
      end
      assign lvl[g] = sr[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign scl_rise = lvl[0] & ~lvl_q[0];
  assign scl_fall = ~lvl[0] & lvl_q[0];
  assign sda_lvl  = lvl[1];
  assign start_ev = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
  assign stop_ev  = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
endmodule

// File: rtl/spd_i2c_fsm.sv
module spd_i2c_fsm
  import spd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  sda_lvl,
  input  logic                  start_ev,
  input  logic                  stop_ev,
  input  logic [6:0]            dev_addr,
  input  logic [SPD_BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]     ptr,
  output logic                  wr_req,
  output logic [SPD_BYTE_W-1:0] wr_data,
  output logic                  bus_idle,
  output logic                  sda_oe
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_BIT  = 4'd8;

  spd_state_e            state, nxt;
  logic [3:0]            bitcnt;
  logic                  in_ack, ack_pend, wrote_one, mack;
  logic [SPD_BYTE_W-1:0] shreg, txsh, rx_byte;
  logic                  rx_state, byte_done;

  assign rx_byte   = {shreg[SPD_BYTE_W-2:0], sda_lvl};
  assign rx_state  = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WDATA);
  assign byte_done = scl_rise && !in_ack && (bitcnt == LAST_BIT) && !start_ev && !stop_ev;
  assign wr_req    = (state == ST_WDATA) && byte_done && !wrote_one;
  assign wr_data   = rx_byte;
  assign bus_idle  = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      ack_pend  <= 1'b0;
      wrote_one <= 1'b0;
      mack      <= 1'b0;
      shreg     <= '0;
      txsh      <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
    end else if (start_ev) begin
      state     <= ST_DEV;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      wrote_one <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && !in_ack && bitcnt < ACK_BIT) begin
        shreg  <= rx_byte;
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt == LAST_BIT) begin
          unique case (state)
            ST_DEV: begin
              ack_pend <= (rx_byte[7:1] == dev_addr);
              if (rx_byte[7:1] != dev_addr) nxt <= ST_IGNORE;
              else if (rx_byte[0])          nxt <= ST_READ;
              else                          nxt <= ST_WORD;
            end
            ST_WORD: begin
              ptr      <= rx_byte[ADDR_W-1:0];
              ack_pend <= 1'b1;
              nxt      <= ST_WDATA;
            end
            default: begin
              if (!wrote_one) begin
                ptr       <= ptr + 1'b1;
                wrote_one <= 1'b1;
                ack_pend  <= 1'b1;
                nxt       <= ST_WDATA;
              end else begin
                ack_pend <= 1'b0;
                nxt      <= ST_IGNORE;
              end
            end
          endcase
        end
      end else if (scl_fall && !in_ack && bitcnt == ACK_BIT) begin
        sda_oe <= ack_pend;
        in_ack <= 1'b1;
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        state  <= nxt;
        if (nxt == ST_READ) begin
          txsh   <= rd_data;
          sda_oe <= ~rd_data[SPD_BYTE_W-1];
        end else begin
          sda_oe <= 1'b0;
        end
      end
    end else if (state == ST_READ) begin
      if (scl_rise && !in_ack && bitcnt < ACK_BIT) begin
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt == LAST_BIT) ptr <= ptr + 1'b1;
      end else if (scl_rise && in_ack) begin
        mack <= ~sda_lvl;
      end else if (scl_fall && !in_ack && bitcnt == ACK_BIT) begin
        sda_oe <= 1'b0;
        in_ack <= 1'b1;
      end else if (scl_fall && !in_ack && bitcnt != 4'd0) begin
        txsh   <= {txsh[SPD_BYTE_W-2:0], 1'b0};
        sda_oe <= ~txsh[SPD_BYTE_W-2];
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        if (mack) begin
          bitcnt <= '0;
          txsh   <= rd_data;
          sda_oe <= ~rd_data[SPD_BYTE_W-1];
        end else begin
          state  <= ST_IGNORE;
          sda_oe <= 1'b0;
        end
      end
    end else begin
      sda_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/spd_csum.sv
module spd_csum
  import spd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CSUM_LAST = 63
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic [SPD_BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]     rd_idx,
  output logic                  ok
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(CSUM_LAST);

  logic                  busy;
  logic [SPD_BYTE_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      rd_idx <= '0;
      acc    <= '0;
      busy   <= 1'b1;
      ok     <= 1'b0;
    end else if (busy) begin
      if (rd_idx == LAST_IDX) begin
        ok   <= (acc == rd_data);
        busy <= 1'b0;
      end else begin
        acc    <= acc + rd_data;
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom
  import spd_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         CSUM_LAST   = 63,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [7:0]        pl_data,
  input  logic              lock_req,
  output logic              locked,
  output logic              csum_ok
);
  localparam int                DEPTH      = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LOCK_BOUND = ADDR_W'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] CSUM_TOP   = ADDR_W'(CSUM_LAST);

  logic [SPD_BYTE_W-1:0] mem [DEPTH];

  logic scl_rise, scl_fall, sda_lvl, start_ev, stop_ev;
  logic [ADDR_W-1:0]     ptr, csum_idx, waddr;
  logic                  fsm_wr, bus_idle, pl_fire, commit;
  logic [SPD_BYTE_W-1:0] fsm_wdata, wdata;

  spd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_lvl),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  spd_i2c_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_lvl),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .dev_addr ({DEV_PREFIX, strap}),
    .rd_data  (mem[ptr]),
    .ptr      (ptr),
    .wr_req   (fsm_wr),
    .wr_data  (fsm_wdata),
    .bus_idle (bus_idle),
    .sda_oe   (sda_oe)
  );

  spd_csum #(.ADDR_W(ADDR_W), .CSUM_LAST(CSUM_LAST)) u_csum (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (commit && (waddr <= CSUM_TOP)),
    .rd_data (mem[csum_idx]),
    .rd_idx  (csum_idx),
    .ok      (csum_ok)
  );

  assign pl_ready = bus_idle;
  assign pl_fire  = pl_valid && pl_ready;
  assign waddr    = fsm_wr ? ptr : pl_addr;
  assign wdata    = fsm_wr ? fsm_wdata : pl_data;
  assign commit   = (fsm_wr || pl_fire) && !(locked && (waddr < LOCK_BOUND));

  always_ff @(posedge clk) begin
    if (!rst_n)        locked <= 1'b0;
    else if (lock_req) locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk #(
  parameter int ADDR_W    = 8,
  parameter int CSUM_LAST = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic              pl_valid,
  input logic              pl_ready,
  input logic [ADDR_W-1:0] pl_addr,
  input logic              lock_req,
  input logic              locked,
  input logic              csum_ok
);
  localparam logic [ADDR_W-1:0] CSUM_TOP = ADDR_W'(CSUM_LAST);

  p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  p_ready_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !pl_ready);

  p_lock_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> locked);

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_csum_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready && !locked && pl_addr <= CSUM_TOP) |=> !csum_ok);
endmodule

bind spd_eeprom spd_eeprom_chk #(.ADDR_W(ADDR_W), .CSUM_LAST(CSUM_LAST)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_in   (scl_in),
  .sda_oe   (sda_oe),
  .pl_valid (pl_valid),
  .pl_ready (pl_ready),
  .pl_addr  (pl_addr),
  .lock_req (lock_req),
  .locked   (locked),
  .csum_ok  (csum_ok)
);

// File: tb/spd_eeprom_tb.sv
module spd_eeprom_tb;
  localparam int       Q     = 5;
  localparam bit [2:0] STRAP = 3'b101;
  localparam bit [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
  localparam bit [7:0] DEVR  = {4'b1010, STRAP, 1'b1};
  localparam int       NVEC  = 12;
  // op: 0 preload, 1 I2C write, 2 I2C random read; {op, addr, data, expected}
  localparam logic [25:0] VECS [NVEC] = '{
    {2'd0, 8'h00, 8'h80, 8'h00}, {2'd0, 8'h01, 8'h08, 8'h00},
    {2'd2, 8'h00, 8'h00, 8'h80}, {2'd2, 8'h01, 8'h00, 8'h08},
    {2'd1, 8'h90, 8'h5A, 8'h00}, {2'd2, 8'h90, 8'h00, 8'h5A},
    {2'd1, 8'h10, 8'h33, 8'h00}, {2'd2, 8'h10, 8'h00, 8'h33},
    {2'd0, 8'hFF, 8'hC3, 8'h00}, {2'd2, 8'hFF, 8'h00, 8'hC3},
    {2'd1, 8'hFE, 8'h11, 8'h00}, {2'd2, 8'hFE, 8'h00, 8'h11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, pl_ready, locked, csum_ok;
  logic pl_valid = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;
  logic lock_req = 1'b0;
  wire  sda_bus = ~(sda_oe | m_low);

  int n_chk = 0, n_err = 0, r9_viol = 0;
  bit done = 1'b0, oe_prev = 1'b0, rd_ok;
  logic [7:0] rbuf [4];

  always #2.5 clk = ~clk;

  spd_eeprom u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .strap(STRAP), .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_addr(pl_addr),
    .pl_data(pl_data), .lock_req(lock_req), .locked(locked), .csum_ok(csum_ok)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_start();
    wq(); m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wq(); m_low = ~b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
    end
    wq(); m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = ~sda_bus; wq(); scl = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      wq(); m_low = 1'b0; wq(); scl = 1'b1; wq(); b[i] = sda_bus; wq(); scl = 1'b0;
    end
    wq(); m_low = mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
  endtask

  task automatic i2c_wr(input logic [7:0] a, input logic [7:0] d, output bit ok);
    bit a1, a2, a3;
    bus_start(); send(DEVW, a1); send(a, a2); send(d, a3); bus_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic i2c_rd(input logic [7:0] a, input int n);
    bit a1, a2, a3;
    bus_start(); send(DEVW, a1); send(a, a2);
    bus_start(); send(DEVR, a3);
    for (int k = 0; k < n; k++) recv(rbuf[k], k < n - 1);
    bus_stop();
    rd_ok = a1 & a2 & a3;
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    pl_valid = 1'b1; pl_addr = a; pl_data = d;
    while (!pl_ready) @(negedge clk);
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  initial begin
    bit ok, a1, a2, a3, a4;
    do_reset();
    chk("R8 sda_oe after reset", sda_oe, 0);
    chk("R8 locked after reset", locked, 0);
    chk("R8 pl_ready after reset", pl_ready, 1);
    repeat (70) @(negedge clk);
    chk("R8 csum_ok on zeroed memory", csum_ok, 1);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op;
      logic [7:0] va, vd, ve;
      {op, va, vd, ve} = VECS[v];
      if (op == 2'd0) preload(va, vd);
      else if (op == 2'd1) begin
        i2c_wr(va, vd, ok);
        chk("R1 R10 write acknowledged", ok, 1);
      end else begin
        i2c_rd(va, 1);
        chk("R1 read addressing acknowledged", rd_ok, 1);
        chk("R2 R6 R10 random read data", rbuf[0], ve);
      end
    end

    // R3: sequential read wraps 0xFF -> 0x00
    i2c_rd(8'hFE, 4);
    chk("R3 seq byte FE", rbuf[0], 8'h11);
    chk("R3 seq byte FF", rbuf[1], 8'hC3);
    chk("R3 seq wrap to 00", rbuf[2], 8'h80);
    chk("R3 seq byte 01", rbuf[3], 8'h08);

    // R1: wrong strap value is ignored
    bus_start(); send({4'b1010, 3'b011, 1'b0}, a1); bus_stop();
    chk("R1 foreign address not acknowledged", a1, 0);

    // R6: preload port closed during a transaction
    bus_start(); send(DEVW, a1);
    chk("R6 pl_ready low in transaction", pl_ready, 0);
    bus_stop();
    chk("R6 pl_ready high after stop", pl_ready, 1);

    // R4: only one data byte per write
    bus_start(); send(DEVW, a1); send(8'hA0, a2); send(8'h44, a3); send(8'h55, a4); bus_stop();
    chk("R4 first data byte acked", a3, 1);
    chk("R4 second data byte not acked", a4, 0);
    i2c_rd(8'hA0, 2);
    chk("R4 first byte stored", rbuf[0], 8'h44);
    chk("R4 second byte not stored", rbuf[1], 8'h00);

    // R7: checksum over bytes 0..62 = 0x80+0x08+0x33 = 0xBB, byte 63 = 0
    repeat (70) @(negedge clk);
    chk("R7 mismatched checksum", csum_ok, 0);
    preload(8'd63, 8'hBB);
    repeat (70) @(negedge clk);
    chk("R7 matching checksum", csum_ok, 1);
    pl_valid = 1'b1; pl_addr = 8'd62; pl_data = 8'h00;
    @(negedge clk);
    pl_valid = 1'b0;
    chk("R7 flag drops after write in range", csum_ok, 0);
    repeat (70) @(negedge clk);
    chk("R7 flag restored after rescan", csum_ok, 1);

    // R5: lock
    @(negedge clk); lock_req = 1'b1; @(negedge clk); lock_req = 1'b0;
    chk("R5 locked set", locked, 1);
    i2c_wr(8'h10, 8'h77, ok);
    chk("R5 locked write still acked", ok, 1);
    i2c_rd(8'h10, 1);
    chk("R5 locked byte unchanged", rbuf[0], 8'h33);
    preload(8'h02, 8'h99);
    i2c_rd(8'h02, 1);
    chk("R5 locked preload ignored", rbuf[0], 8'h00);
    i2c_wr(8'h90, 8'h66, ok);
    i2c_rd(8'h90, 1);
    chk("R5 upper half writable when locked", rbuf[0], 8'h66);
    chk("R5 lock persists", locked, 1);

    chk("R9 sda_oe never rose with SCL high", r9_viol, 0);

    do_reset();
    chk("R8 lock cleared by reset", locked, 0);
    i2c_rd(8'h90, 1);
    chk("R8 memory cleared by reset", rbuf[0], 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule